// File: doc/BRIEF.md
# Partially Approximate Ripple-Carry Adder

This block adds two N-bit operands and a carry-in through a chain of one-bit adder cells. The lowest K cells trade accuracy for area: each uses a simplified one-bit cell whose truth table departs from true addition for some inputs. The cells above them are ordinary full adders. The cell type is fixed at elaboration by a variant parameter, and so is the number of simplified positions. Error-tolerant datapaths such as pixel filters and iterative integer kernels can use it where a small error in the low bits is acceptable.

The block is purely combinational. Results follow the operands within the same cycle, and there is no handshake. A surrounding pipeline registers the result wherever its timing needs it. The carry leaving the top simplified cell enters the lowest exact cell unchanged. The carry-out is the carry leaving bit N-1. The only legal variant codes are 0, 1 and 3. Any other code stops elaboration, and so does K greater than N.

Top module: `apx_ripple_adder`

## Requirements
- R1: Every bit position i with i >= K behaves as an exact full adder. Its sum is a^b^c and its carry is the majority of a, b and c, where c is the carry arriving at position i.
- R2: With VARIANT=0, each simplified cell produces the exact majority carry, and its sum is the inverse of that carry. Input abc=000 gives sum 1, input 111 gives sum 0, and all other inputs match exact addition.
- R3: With VARIANT=1, each simplified cell's carry is b | (a & c) and its sum is the inverse of that carry. It differs from VARIANT=0 only at a=0, b=1, c=0, where it gives sum 0 and carry 1.
- R4: With VARIANT=3, each simplified cell's sum equals its b input and its carry equals its a input, whatever the arriving carry.
- R5: The carry leaving position K-1 enters position K unchanged, and carry_out is the carry leaving position N-1.
- R6: With K=0, {carry_out, sum} equals op_a + op_b + carry_in exactly, for any VARIANT.
- R7: K may be any value from 1 to N, including K=N. K values of 4, 8, 12 and 16 work on datapaths of 16 bits or wider.
- R8: The outputs depend only on the present inputs, with no storage. A new operand pair gives its result before the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | N | Sum bits, low K of them simplified |
| carry_out | output | 1 | Carry leaving bit N-1 |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between operands and outputs. The bench drives a new operand set, waits two nanoseconds, and compares the outputs. That is well inside one 8 ns clock period and far from the next edge. The expected values come from a bit-by-bit model of the three simplified cells, not from exact addition. The one-bit sweeps compare against the cell truth tables directly.

// File: rtl/apx_pkg.sv
package apx_pkg;

  typedef enum logic [1:0] {
    FA_EXACT = 2'd0,
    FA_V0    = 2'd1,
    FA_V1    = 2'd2,
    FA_V3    = 2'd3
  } fa_kind_e;

  function automatic logic variant_ok(int unsigned v);
    return (v == 0) || (v == 1) || (v == 3);
  endfunction

  function automatic fa_kind_e kind_of(int unsigned v);
    case (v)
      0:       return FA_V0;
      1:       return FA_V1;
      3:       return FA_V3;
      default: return FA_EXACT;
    endcase
  endfunction

endpackage

// File: rtl/apx_fa_cell.sv
module apx_fa_cell #(
  parameter apx_pkg::fa_kind_e KIND = apx_pkg::FA_EXACT
) (
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic s,
  output logic cout
);
  import apx_pkg::*;

  generate
    if (KIND == FA_EXACT) begin : g_exact
      always_comb begin
        cout = (a & b) | (a & cin) | (b & cin);
        s    = a ^ b ^ cin;
      end
    end else if (KIND == FA_V0) begin : g_v0
      // Exact majority carry; sum is its complement.
      always_comb begin
        cout = (a & b) | (a & cin) | (b & cin);
        s    = ~cout;
      end
    end else if (KIND == FA_V1) begin : g_v1
      always_comb begin
        cout = b | (a & cin);
        s    = ~cout;
      end
    end else begin : g_v3
      // Wires only: arriving carry is not consulted.
      logic unused_cin;
      assign unused_cin = cin;
      assign s    = b;
      assign cout = a;
    end
  endgenerate

endmodule

// File: rtl/apx_fa_chain.sv
module apx_fa_chain #(
  parameter int unsigned       W    = 8,
  parameter apx_pkg::fa_kind_e KIND = apx_pkg::FA_EXACT
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  import apx_pkg::*;

  localparam int unsigned CW = W + 1;

  logic [W:0] carry;
  assign carry[0] = cin;
  assign cout     = carry[W];

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      apx_fa_cell #(.KIND(KIND)) u_cell (
        .a    (a[i]),
        .b    (b[i]),
        .cin  (carry[i]),
        .s    (s[i]),
        .cout (carry[i+1])
      );
    end

    if (KIND == FA_EXACT) begin : g_chk_exact
      logic [CW-1:0] ref_exact;
      assign ref_exact = {1'b0, a} + {1'b0, b} + CW'(cin);
      always_comb begin
        p_exact_cells_r1: assert ({cout, s} == ref_exact)
          else $error("exact segment mismatch");
      end
    end else if (KIND == FA_V0) begin : g_chk_v0
      logic [CW-1:0] ref_exact;
      assign ref_exact = {1'b0, a} + {1'b0, b} + CW'(cin);
      always_comb begin
        p_v0_carry_exact_r2: assert (cout == ref_exact[W])
          else $error("variant 0 carry departs from exact");
      end
    end else if (KIND == FA_V1) begin : g_chk_v1
      always_comb begin
        for (int i = 0; i < int'(W); i++) begin
          p_v1_b_sets_carry_r3: assert (!b[i] || (carry[i+1] && !s[i]))
            else $error("variant 1 cell with b=1 lacks carry");
        end
      end
    end else begin : g_chk_v3
      always_comb begin
        p_v3_wires_r4: assert ((s == b) && (cout == a[W-1]))
          else $error("variant 3 segment not pass-through");
      end
    end
  endgenerate

endmodule

// File: rtl/apx_ripple_adder.sv
module apx_ripple_adder #(
  parameter int unsigned N       = 32,
  parameter int unsigned K       = 8,
  parameter int unsigned VARIANT = 0
) (
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  input  logic         carry_in,
  output logic [N-1:0] sum,
  output logic         carry_out
);
  import apx_pkg::*;

  localparam int unsigned HI_W = N - K;
  localparam fa_kind_e    LO_KIND = kind_of(VARIANT);

  generate
    if (!variant_ok(VARIANT)) begin : g_bad_variant
      $error("VARIANT must be 0, 1 or 3");
    end
    if (K > N || N < 1) begin : g_bad_k
      $error("K must lie in 0..N and N must be at least 1");
    end
  endgenerate

  logic mid_carry;

  generate
    if (K > 0) begin : g_lo
      apx_fa_chain #(.W(K), .KIND(LO_KIND)) u_lo (
        .a    (op_a[K-1:0]),
        .b    (op_b[K-1:0]),
        .cin  (carry_in),
        .s    (sum[K-1:0]),
        .cout (mid_carry)
      );
    end else begin : g_no_lo
      assign mid_carry = carry_in;
    end

    if (HI_W > 0) begin : g_hi
      apx_fa_chain #(.W(HI_W), .KIND(FA_EXACT)) u_hi (
        .a    (op_a[N-1:K]),
        .b    (op_b[N-1:K]),
        .cin  (mid_carry),
        .s    (sum[N-1:K]),
        .cout (carry_out)
      );
    end else begin : g_no_hi
      assign carry_out = mid_carry;
    end

    if (K == 0) begin : g_chk_k0
      logic [N:0] ref_full;
      assign ref_full = {1'b0, op_a} + {1'b0, op_b} + (N+1)'(carry_in);
      always_comb begin
        p_exact_k0_r6: assert ({carry_out, sum} == ref_full)
          else $error("K=0 adder not exact");
      end
    end
  endgenerate

endmodule

// File: tb/apx_ripple_adder_test.sv
`timescale 1ns/1ps
module apx_ripple_adder_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic a1, b1, c1;
  logic [31:0] a32, b32;
  logic [23:0] a24, b24;
  logic [15:0] a16, b16;
  logic cin;

  logic        s1_v0, s1_v1, s1_v3, k1_v0, k1_v1, k1_v3;
  logic [31:0] s_uut, s_k0;
  logic        c_uut, c_k0;
  logic [15:0] s_16v3, s_16v1, s_16v0;
  logic        c_16v3, c_16v1, c_16v0;
  logic [23:0] s_24v1;
  logic        c_24v1;

  apx_ripple_adder uut (.op_a(a32), .op_b(b32), .carry_in(cin), .sum(s_uut), .carry_out(c_uut));
  apx_ripple_adder #(.N(1), .K(1), .VARIANT(0)) u1_v0 (.op_a(a1), .op_b(b1), .carry_in(c1), .sum(s1_v0), .carry_out(k1_v0));
  apx_ripple_adder #(.N(1), .K(1), .VARIANT(1)) u1_v1 (.op_a(a1), .op_b(b1), .carry_in(c1), .sum(s1_v1), .carry_out(k1_v1));
  apx_ripple_adder #(.N(1), .K(1), .VARIANT(3)) u1_v3 (.op_a(a1), .op_b(b1), .carry_in(c1), .sum(s1_v3), .carry_out(k1_v3));
  apx_ripple_adder #(.N(32), .K(0), .VARIANT(3)) u_k0 (.op_a(a32), .op_b(b32), .carry_in(cin), .sum(s_k0), .carry_out(c_k0));
  apx_ripple_adder #(.N(16), .K(16), .VARIANT(3)) u_16v3 (.op_a(a16), .op_b(b16), .carry_in(cin), .sum(s_16v3), .carry_out(c_16v3));
  apx_ripple_adder #(.N(16), .K(4), .VARIANT(1)) u_16v1 (.op_a(a16), .op_b(b16), .carry_in(cin), .sum(s_16v1), .carry_out(c_16v1));
  apx_ripple_adder #(.N(16), .K(12), .VARIANT(0)) u_16v0 (.op_a(a16), .op_b(b16), .carry_in(cin), .sum(s_16v0), .carry_out(c_16v0));
  apx_ripple_adder #(.N(24), .K(24), .VARIANT(1)) u_24v1 (.op_a(a24), .op_b(b24), .carry_in(cin), .sum(s_24v1), .carry_out(c_24v1));

  // Bit-level model of the cells, written from the requirements.
  function automatic logic [32:0] model(int n, int k, int v,
                                        logic [31:0] a, logic [31:0] b, logic ci);
    logic c = ci;
    logic [31:0] s = '0;
    logic cn;
    for (int i = 0; i < n; i++) begin
      if (i < k) begin
        case (v)
          0: begin cn = (a[i]&b[i])|(a[i]&c)|(b[i]&c); s[i] = ~cn; end
          1: begin cn = b[i] | (a[i]&c); s[i] = ~cn; end
          default: begin cn = a[i]; s[i] = b[i]; end
        endcase
      end else begin
        cn   = (a[i]&b[i])|(a[i]&c)|(b[i]&c);
        s[i] = a[i]^b[i]^c;
      end
      c = cn;
    end
    return {c, s};
  endfunction

  task automatic chk(string tag, logic [32:0] act, logic [32:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] a, logic [31:0] b, logic ci);
    a32 = a; b32 = b; a24 = a[23:0]; b24 = b[23:0];
    a16 = a[15:0]; b16 = b[15:0]; cin = ci;
    #2;
  endtask

  task automatic check_all(string tag);
    chk({"R2 uut ", tag}, {c_uut, s_uut}, model(32, 8, 0, a32, b32, cin));
    chk({"R6 k0 ", tag}, {c_k0, s_k0}, model(32, 0, 3, a32, b32, cin));
    chk({"R4 R7 16v3 ", tag}, {c_16v3, 16'h0, s_16v3}, model(16, 16, 3, a32, b32, cin));
    chk({"R3 R5 16v1 ", tag}, {c_16v1, 16'h0, s_16v1}, model(16, 4, 1, a32, b32, cin));
    chk({"R2 R1 16v0 ", tag}, {c_16v0, 16'h0, s_16v0}, model(16, 12, 0, a32, b32, cin));
    chk({"R3 R7 24v1 ", tag}, {c_24v1, 8'h0, s_24v1}, model(24, 24, 1, a32, b32, cin));
  endtask

  // All-zero operands: variant 0 raises sum bits in its simplified positions.
  task automatic t_zero_inputs();
    a1 = 0; b1 = 0; c1 = 0;
    drive('0, '0, 1'b0);
    chk("R2 zero low bits", {c_uut, s_uut}, {1'b0, 32'h0000_00FF});
    chk("R6 zero exact", {c_k0, s_k0}, 33'h0);
  endtask

  // Truth-table sweep of single cells (R2, R3, R4).
  task automatic t_cell_sweep();
    for (int x = 0; x < 8; x++) begin
      logic ea, eb, ec, mj;
      ea = x[2]; eb = x[1]; ec = x[0];
      a1 = ea; b1 = eb; c1 = ec;
      #2;
      mj = (ea&eb)|(ea&ec)|(eb&ec);
      chk("R2 cell v0", {31'h0, k1_v0, s1_v0}, {31'h0, mj, ~mj});
      chk("R3 cell v1", {31'h0, k1_v1, s1_v1}, {31'h0, eb|(ea&ec), ~(eb|(ea&ec))});
      chk("R4 cell v3", {31'h0, k1_v3, s1_v3}, {31'h0, ea, eb});
    end
    a1 = 0; b1 = 1; c1 = 0; #2;
    chk("R3 v1 differs at 010", {31'h0, k1_v1, s1_v1}, {31'h0, 1'b1, 1'b0});
    chk("R2 v0 exact at 010", {31'h0, k1_v0, s1_v0}, {31'h0, 1'b0, 1'b1});
  endtask

  // Carry from the simplified region crossing into the exact region (R5).
  task automatic t_carry_cross();
    drive(32'h0000_00FF, 32'h0, 1'b1);
    chk("R5 v0 carry ripples up", {c_uut, s_uut}, {1'b0, 32'h0000_0100});
    check_all("cross1");
    drive(32'h0000_0800, 32'h0000_0000, 1'b0);
    chk("R5 R4 v3 a msb feeds exact", {c_16v3, 16'h0, s_16v3}, {1'b0, 32'h0});
    drive(32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
    chk("R5 carry_out top", {c_k0, s_k0}, {1'b1, 32'h0});
    check_all("cross2");
  endtask

  // Fresh operands give results within the cycle (R8).
  task automatic t_same_cycle();
    drive(32'h1234_5678, 32'h0F0F_0F0F, 1'b0);
    chk("R8 settle k0", {c_k0, s_k0}, {1'b0, 32'h2143_6587});
    drive(32'h0000_0001, 32'h0000_0001, 1'b1);
    chk("R8 settle k0 again", {c_k0, s_k0}, {1'b0, 32'h3});
  endtask

  task automatic t_random(int count);
    for (int i = 0; i < count; i++) begin
      drive($urandom, $urandom, 1'($urandom));
      check_all("rand");
    end
  endtask

  task automatic t_extremes();
    drive('1, '1, 1'b1);
    check_all("all ones");
    drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b0);
    check_all("alternating");
    drive(32'h5555_5555, 32'hAAAA_AAAA, 1'b1);
    check_all("alternating ci");
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    a1 = 0; b1 = 0; c1 = 0;
    a32 = '0; b32 = '0; a24 = '0; b24 = '0; a16 = '0; b16 = '0; cin = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_zero_inputs();
    t_cell_sweep();
    t_carry_cross();
    t_same_cycle();
    t_extremes();
    t_random(300);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule